// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block drives a single port of up to 32 general-purpose pins from a simple 32-bit register bus. Software can reach the port in several ways. It can address one pin at a time through a byte alias or a word alias. It can move the whole port at once through a raw view or through a view gated by a mask. It can flip individual bits of the output latch or of the direction vector, using write-only set, clear and toggle registers that need no read-modify-write.

Incoming pad levels pass through a two-stage synchroniser, and every read that reports pin state sees that synchronised value. Each pad's output enable follows its direction bit, and the pad's output level follows its latch bit. The bus has no wait states. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of the address and the current state.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output latch, the direction vector and the mask are all zero, so `pad_out` and `pad_oe` are 0. `bus_ready` is high at all times.
- R2: The byte alias of pin p is at address p (0x0000 to 0x001F). A write with the strobe of lane p[1:0] set loads bit 0 of that lane (wdata bit 8*p[1:0]) into latch bit p. If that strobe is clear, the write is ignored. A read returns the synchronised pin level in bit 8*p[1:0] and zero in all other bits.
- R3: The word alias of pin p is at 0x1000+4*p. A read returns 0x00000000 when the synchronised pin is low and 0xFFFFFFFF when it is high. A write with any strobe set drives latch bit p high if the strobed data bytes are nonzero, and low otherwise.
- R4: The direction register at 0x2000 is readable and writable, 1 meaning output. `pad_oe` equals the direction vector and `pad_out` equals the latch.
- R5: The mask register at 0x2080 is readable and writable. A write to the masked port at 0x2180 changes only the latch bits whose mask bit is 0. A read of 0x2180 returns the synchronised pins with every bit whose mask bit is 1 forced to 0.
- R6: The raw port at 0x2100 reads the synchronised pins and writes the whole latch, regardless of the mask.
- R7: A write to 0x2200 sets the latch bits written as 1. A read of 0x2200 returns the latch.
- R8: A write to 0x2280 clears, and a write to 0x2300 inverts, the latch bits written as 1. Bits written as 0 keep their value.
- R9: Writes to 0x2380, 0x2400 and 0x2480 respectively set, clear and invert the direction bits written as 1.
- R10: Reads of the write-only registers (0x2280, 0x2300, 0x2380, 0x2400, 0x2480) and of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R11: On whole-port registers only the bytes whose strobe is set are affected. A write with no strobe set, and any cycle with `bus_we` low, changes no state.
- R12: A level change on `pad_in` is first visible to reads after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 14 | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_ready | output | 1 | Always high; no wait states |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Pad output levels (the latch) |
| pad_oe | output | NPINS | Pad output enables (the direction vector) |

## Verification
The bench builds the block with its default of 32 pins. At that width every bit of the 32-bit bus maps to a pin, so every byte lane, the last word alias at 0x107C and the top-bit behaviour of the masked view can all be reached. Holding a fixed, asymmetric pattern on the pads lets the raw, masked, byte and word read paths each be told apart. The same holding allows the synchroniser latency to be counted edge by edge after a change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFF_WORD  = 14'h1000;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 14'h2000;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 14'h2080;
  localparam logic [ADDR_W-1:0] OFF_PORT  = 14'h2100;
  localparam logic [ADDR_W-1:0] OFF_MPORT = 14'h2180;
  localparam logic [ADDR_W-1:0] OFF_SET   = 14'h2200;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 14'h2280;
  localparam logic [ADDR_W-1:0] OFF_TGL   = 14'h2300;
  localparam logic [ADDR_W-1:0] OFF_DSET  = 14'h2380;
  localparam logic [ADDR_W-1:0] OFF_DCLR  = 14'h2400;
  localparam logic [ADDR_W-1:0] OFF_DTGL  = 14'h2480;

  typedef enum logic [3:0] {
    RK_NONE, RK_BYTE, RK_WORD, RK_DIR, RK_MASK, RK_PORT, RK_MPORT,
    RK_SET, RK_CLR, RK_TGL, RK_DSET, RK_DCLR, RK_DTGL
  } reg_kind_e;

  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [PIN_W-1:0]  pin
);
  localparam logic [ADDR_W-1:0] BYTE_END = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] WORD_END = OFF_WORD + ADDR_W'(4 * NPINS);

  logic [ADDR_W-1:0] word_off;

  always_comb begin
    word_off = addr - OFF_WORD;
    kind     = RK_NONE;
    pin      = '0;
    if (addr < BYTE_END) begin
      kind = RK_BYTE;
      pin  = addr[PIN_W-1:0];
    end else if (addr >= OFF_WORD && addr < WORD_END && addr[1:0] == 2'b00) begin
      kind = RK_WORD;
      pin  = word_off[PIN_W+1:2];
    end else begin
      case (addr)
        OFF_DIR:   kind = RK_DIR;
        OFF_MASK:  kind = RK_MASK;
        OFF_PORT:  kind = RK_PORT;
        OFF_MPORT: kind = RK_MPORT;
        OFF_SET:   kind = RK_SET;
        OFF_CLR:   kind = RK_CLR;
        OFF_TGL:   kind = RK_TGL;
        OFF_DSET:  kind = RK_DSET;
        OFF_DCLR:  kind = RK_DCLR;
        OFF_DTGL:  kind = RK_DTGL;
        default:   kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_kind_e         kind,
  input  logic [PIN_W-1:0]  pin,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  mask_q
);
  logic [DATA_W-1:0] full_wm;
  logic [NPINS-1:0]  wm;
  logic [NPINS-1:0]  wd;
  logic [NPINS-1:0]  latch_n, dir_n, mask_n;
  logic              latch_en, dir_en, mask_en;

  // next-state
  always_comb begin
    full_wm = lane_bits(be);
    wm      = full_wm[NPINS-1:0];
    wd      = wdata[NPINS-1:0] & wm;
    latch_n = latch_q;
    dir_n   = dir_q;
    mask_n  = mask_q;
    case (kind)
      RK_BYTE:  if (be[pin[1:0]]) latch_n[pin] = wdata[{pin[1:0], 3'b000}];
      RK_WORD:  if (|be) latch_n[pin] = |(wdata & full_wm);
      RK_PORT:  latch_n = (latch_q & ~wm) | wd;
      RK_MPORT: latch_n = (latch_q & ~(wm & ~mask_q)) | (wd & ~mask_q);
      RK_SET:   latch_n = latch_q | wd;
      RK_CLR:   latch_n = latch_q & ~wd;
      RK_TGL:   latch_n = latch_q ^ wd;
      RK_DIR:   dir_n   = (dir_q & ~wm) | wd;
      RK_DSET:  dir_n   = dir_q | wd;
      RK_DCLR:  dir_n   = dir_q & ~wd;
      RK_DTGL:  dir_n   = dir_q ^ wd;
      RK_MASK:  mask_n  = (mask_q & ~wm) | wd;
      default:  ;
    endcase
    latch_en = we && (kind inside {RK_BYTE, RK_WORD, RK_PORT, RK_MPORT,
                                   RK_SET, RK_CLR, RK_TGL});
    dir_en   = we && (kind inside {RK_DIR, RK_DSET, RK_DCLR, RK_DTGL});
    mask_en  = we && (kind == RK_MASK);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (latch_en) latch_q <= latch_n;
      if (dir_en)   dir_q   <= dir_n;
      if (mask_en)  mask_q  <= mask_n;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam int PIN_W = $clog2(NPINS);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  reg_kind_e        kind;
  logic [PIN_W-1:0] pin;
  logic [NPINS-1:0] pins_s, latch_q, dir_q, mask_q;
  logic [DATA_W-1:0] rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .d(pad_in), .q(pins_s)
  );

  gpio_decode #(.NPINS(NPINS)) dec_i (
    .addr(bus_addr), .kind(kind), .pin(pin)
  );

  gpio_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .we(bus_we), .kind(kind), .pin(pin),
    .be(bus_be), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .mask_q(mask_q)
  );

  always_comb begin
    rd = '0;
    case (kind)
      RK_BYTE:  rd[{pin[1:0], 3'b000}] = pins_s[pin];
      RK_WORD:  rd = {DATA_W{pins_s[pin]}};
      RK_DIR:   rd[NPINS-1:0] = dir_q;
      RK_MASK:  rd[NPINS-1:0] = mask_q;
      RK_PORT:  rd[NPINS-1:0] = pins_s;
      RK_MPORT: rd[NPINS-1:0] = pins_s & ~mask_q;
      RK_SET:   rd[NPINS-1:0] = latch_q;
      default:  rd = '0;
    endcase
  end

  assign bus_rdata = rd;
  assign bus_ready = 1'b1;
  assign pad_out   = latch_q;
  assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [LANES-1:0]  bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  mask_q
);
  logic full_wr;
  assign full_wr = bus_we && (bus_be == '1);

  // R7
  p_set_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == OFF_SET) |=>
      ((pad_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  // R8
  p_clr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == OFF_CLR) |=>
      ((pad_out & $past(bus_wdata[NPINS-1:0])) == '0));

  // R9
  p_dir_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == OFF_DSET) |=>
      ((pad_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  // R5
  p_masked_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_MPORT) |=>
      ((pad_out & $past(mask_q)) == ($past(pad_out) & $past(mask_q))));

  // R11
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_be == '0) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .mask_q(mask_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam int NPINS = 32;
  localparam int NVEC  = 27;
  localparam logic [31:0] PADS_A = 32'hA5A5_0F0F;
  localparam logic [31:0] PADS_B = 32'h5A5A_F0F0;

  // {write addr, strobes, write data, read addr, expected read, requirement}
  localparam logic [107:0] VEC [NVEC] = '{
    {16'h2000, 4'hF, 32'hFFFF_FFFF, 16'h2000, 32'hFFFF_FFFF, 8'd4},   // R4
    {16'h2100, 4'hF, 32'h1234_5678, 16'h2200, 32'h1234_5678, 8'd6},   // R6
    {16'h2200, 4'hF, 32'h0000_00F0, 16'h2200, 32'h1234_56F8, 8'd7},   // R7
    {16'h2280, 4'hF, 32'h1200_0008, 16'h2200, 32'h0034_56F0, 8'd8},   // R8
    {16'h2300, 4'hF, 32'hFF00_0000, 16'h2200, 32'hFF34_56F0, 8'd8},   // R8
    {16'h2080, 4'hF, 32'hFFFF_0000, 16'h2080, 32'hFFFF_0000, 8'd5},   // R5
    {16'h2180, 4'hF, 32'h0000_0000, 16'h2200, 32'hFF34_0000, 8'd5},   // R5
    {16'h0000, 4'h0, 32'h0000_0000, 16'h2180, 32'h0000_0F0F, 8'd5},   // R5
    {16'h0000, 4'h0, 32'h0000_0000, 16'h2100, 32'hA5A5_0F0F, 8'd6},   // R6
    {16'h2400, 4'hF, 32'h0000_FFFF, 16'h2000, 32'hFFFF_0000, 8'd9},   // R9
    {16'h2480, 4'hF, 32'hFF00_00FF, 16'h2000, 32'h00FF_00FF, 8'd9},   // R9
    {16'h2380, 4'hF, 32'h0000_0F00, 16'h2000, 32'h00FF_0FFF, 8'd9},   // R9
    {16'h2000, 4'h1, 32'h1111_1111, 16'h2000, 32'h00FF_0F11, 8'd11},  // R11
    {16'h0000, 4'h0, 32'h0000_0000, 16'h2280, 32'h0000_0000, 8'd10},  // R10
    {16'h3000, 4'hF, 32'hFFFF_FFFF, 16'h2200, 32'hFF34_0000, 8'd10},  // R10
    {16'h0001, 4'h2, 32'h0000_0100, 16'h2200, 32'hFF34_0002, 8'd2},   // R2
    {16'h0003, 4'h1, 32'h0100_0001, 16'h2200, 32'hFF34_0002, 8'd2},   // R2
    {16'h0000, 4'h0, 32'h0000_0000, 16'h0000, 32'h0000_0001, 8'd2},   // R2
    {16'h0000, 4'h0, 32'h0000_0000, 16'h0009, 32'h0000_0100, 8'd2},   // R2
    {16'h0000, 4'h0, 32'h0000_0000, 16'h0006, 32'h0000_0000, 8'd2},   // R2
    {16'h0000, 4'h0, 32'h0000_0000, 16'h1010, 32'h0000_0000, 8'd3},   // R3
    {16'h0000, 4'h0, 32'h0000_0000, 16'h107C, 32'hFFFF_FFFF, 8'd3},   // R3
    {16'h1008, 4'h4, 32'h0001_0000, 16'h2200, 32'hFF34_0006, 8'd3},   // R3
    {16'h1008, 4'hF, 32'h0000_0000, 16'h2200, 32'hFF34_0002, 8'd3},   // R3
    {16'h1004, 4'h1, 32'h00FF_0000, 16'h2200, 32'hFF34_0000, 8'd3},   // R3
    {16'h2380, 4'h0, 32'hFFFF_FFFF, 16'h2000, 32'h00FF_0F11, 8'd11},  // R11
    {16'h0000, 4'h0, 32'h0000_0000, 16'h2480, 32'h0000_0000, 8'd10}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [NPINS-1:0] pad_in = PADS_A;
  logic [NPINS-1:0] pad_out, pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.NPINS(NPINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [13:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [13:0] a, output logic [31:0] r);
    bus_addr = a;
    #1;
    r = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 ready", 32'(bus_ready), 32'h1);
    bus_read(14'h2000, r); check("R1 dir", r, 32'h0);
    bus_read(14'h2080, r); check("R1 mask", r, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] wa, ra;
      logic [3:0]  be;
      logic [31:0] wd, ex;
      logic [7:0]  rq;
      {wa, be, wd, ra, ex, rq} = VEC[i];
      if (wa != 16'h0 || be != 4'h0) bus_write(wa[13:0], be, wd);
      else @(negedge clk);
      bus_read(ra[13:0], r);
      check($sformatf("R%0d vector %0d", rq, i), r, ex);
    end

    // R4 pads follow direction and latch
    check("R4 pad_oe", 32'(pad_oe), 32'h00FF_0F11);
    check("R4 pad_out", 32'(pad_out), 32'hFF34_0000);

    // R12 synchroniser latency
    @(negedge clk);
    pad_in = PADS_B;
    bus_read(14'h2100, r); check("R12 edge0", r, PADS_A);
    @(negedge clk);
    bus_read(14'h2100, r); check("R12 edge1", r, PADS_A);
    @(negedge clk);
    bus_read(14'h2100, r); check("R12 edge2", r, PADS_B);

    // R1 reset in mid-run clears state asynchronously
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid pad_out", 32'(pad_out), 32'h0);
    check("R1 mid pad_oe", 32'(pad_oe), 32'h0);
    bus_read(14'h2080, r); check("R1 mid mask", r, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule